// File: doc/BRIEF.md
# Orbit-Synchronous Broadcast Command Scheduler

The scheduler tracks the position of the bunch clock within a machine orbit and decides, cycle by cycle, whether an 8-bit broadcast command goes onto the timing-command channel. A bunch-position counter runs from 0 to 3563 and wraps. An orbit-start marker pulls it back to 0 at any time. Each orbit opening, whether from a wrap or from the marker, advances an orbit prescaler.

Two sources share the channel. A fixed command, 0x04, goes out at bunch position 3400 on every tenth orbit. It is always active and has no enable. A user command goes out at bunch position 1024. It is taken from an 8-bit register value and sent once each time software raises a send-request bit. When it goes out, the scheduler pulses an auto-clear line so that the register block drops the request bit by itself. Serial line encoding and the register bus sit outside this block.

Top module: `bcast_sched`

## Requirements
- R1: While rst_ni is low, and until the first command is due, cmd_valid_o, cmd_o and req_clr_o are all zero.
- R2: A high orbit_start_i sampled at clock edge E sets the bunch position to 0 after E. The position then counts up by one per clock and wraps from 3563 to 0, so orbit k after the marker starts after edge E+k*3564.
- R3: A command scheduled at bunch position P appears on the outputs after edge E+k*3564+P+1, where k is the orbit index. The fixed command uses P=3400 and drives cmd_o=0x04 with req_clr_o low.
- R4: The fixed command is sent only in every 10th orbit. Reset preloads the prescaler so that the first orbit opened after reset, by the marker or by a wrap, is a sending orbit. Every orbit opening advances the prescaler by one, including a marker that arrives mid-orbit.
- R5: The fixed command has no enable. It is sent in its orbits whatever the values of send_req_i and user_cmd_i, including in an orbit that also sends a user command.
- R6: If send_req_i is high at the edge where the bunch position is 1024, the value of user_cmd_i at that edge is sent once, using the timing of R3 with P=1024.
- R7: A request raised after position 1024 in an orbit is held and sent at position 1024 of the next orbit.
- R8: req_clr_o is a one-cycle pulse that accompanies each user-command strobe and never accompanies a fixed-command strobe.
- R9: cmd_valid_o is high for exactly one clock per command. cmd_o is 0x00 whenever cmd_valid_o is low.
- R10: With send_req_i low, nothing is sent at position 1024, and orbits that do not send the fixed command carry no strobe at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bunch clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| orbit_start_i | input | 1 | Orbit-start marker; realigns the bunch position to 0 |
| user_cmd_i | input | 8 | User command byte from the register block |
| send_req_i | input | 1 | Send-request bit from the register block |
| cmd_valid_o | output | 1 | One-cycle strobe marking a command on cmd_o |
| cmd_o | output | 8 | Command byte being sent, 0x00 when idle |
| req_clr_o | output | 1 | Pulse telling the register block to clear the request bit |

## Verification
The bench aligns the counter with a marker and records every strobe with its edge number. It then compares the log against edges computed from the orbit length, and the run covers more than one prescale period. Requests are raised well before position 1024 and well after it, which separates immediate sending from deferral to the next orbit. Quiet orbits with send_req_i low show that the prescaler suppresses the fixed command and that the user slot stays empty. A marker issued mid-orbit shows that realignment advances the prescaler, because the next fixed command then lands eight orbits later instead of ten.

// File: rtl/bsched_pkg.sv
package bsched_pkg;
  localparam int unsigned CMD_W = 8;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_FIXED = 2'd1,
    SRC_USER  = 2'd2
  } src_e;
endpackage

// File: rtl/bsched_bx_ctr.sv
module bsched_bx_ctr #(
  parameter int unsigned ORBIT_LEN = 3564,
  parameter int unsigned BX_W      = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            orbit_start_i,
  output logic [BX_W-1:0] bx_o,
  output logic            orbit_begin_o
);
  logic [BX_W-1:0] bx_q;
  logic            last;

  assign last          = (bx_q == BX_W'(ORBIT_LEN - 1));
  assign orbit_begin_o = orbit_start_i | last;
  assign bx_o          = bx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            bx_q <= '0;
    else if (orbit_begin_o) bx_q <= '0;
    else                    bx_q <= bx_q + 1'b1;
  end

  p_bx_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bx_q < BX_W'(ORBIT_LEN));
  p_marker_realign_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    orbit_start_i |=> (bx_q == '0));
endmodule

// File: rtl/bsched_orbit_presc.sv
module bsched_orbit_presc #(
  parameter int unsigned PRESCALE = 10,
  parameter int unsigned PS_W     = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic fire_o
);
  if (PRESCALE <= 1) begin : g_every
    logic unused;
    assign unused = ^{clk_i, rst_ni, step_i};
    assign fire_o = 1'b1;
  end else begin : g_cnt
    logic [PS_W-1:0] cnt_q;

    // preload so the first opened orbit is a sending one
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= PS_W'(PRESCALE - 1);
      else if (step_i) cnt_q <= (cnt_q == PS_W'(PRESCALE - 1)) ? '0 : cnt_q + 1'b1;
    end

    assign fire_o = (cnt_q == '0);

    p_presc_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q < PS_W'(PRESCALE));
    p_fire_one_orbit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fire_o && step_i) |=> !fire_o);
  end
endmodule

// File: rtl/bsched_issue.sv
module bsched_issue
  import bsched_pkg::*;
#(
  parameter logic [CMD_W-1:0] FIXED_CMD = 8'h04
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fixed_hit_i,
  input  logic             user_hit_i,
  input  logic             user_req_i,
  input  logic [CMD_W-1:0] user_cmd_i,
  output logic             cmd_valid_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic             req_clr_o
);
  src_e             sel;
  logic             valid_q;
  logic             clr_q;
  logic [CMD_W-1:0] cmd_q;

  // fixed slot wins if both land on one position
  always_comb begin
    sel = SRC_NONE;
    if (fixed_hit_i)                   sel = SRC_FIXED;
    else if (user_hit_i && user_req_i) sel = SRC_USER;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      clr_q   <= 1'b0;
      cmd_q   <= '0;
    end else begin
      valid_q <= (sel != SRC_NONE);
      clr_q   <= (sel == SRC_USER);
      unique case (sel)
        SRC_FIXED: cmd_q <= FIXED_CMD;
        SRC_USER:  cmd_q <= user_cmd_i;
        default:   cmd_q <= '0;
      endcase
    end
  end

  assign cmd_valid_o = valid_q;
  assign cmd_o       = cmd_q;
  assign req_clr_o   = clr_q;

  p_idle_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_o |-> (cmd_o == '0));
  p_single_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);
  p_clr_with_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_clr_o |-> cmd_valid_o);
  p_clr_needs_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_clr_o) |-> $past(user_req_i));
  p_fixed_value_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !req_clr_o) |-> (cmd_o == FIXED_CMD));
endmodule

// File: rtl/bcast_sched.sv
module bcast_sched
  import bsched_pkg::*;
#(
  parameter int unsigned      ORBIT_LEN = 3564,
  parameter int unsigned      FIXED_POS = 3400,
  parameter int unsigned      USER_POS  = 1024,
  parameter int unsigned      PRESCALE  = 10,
  parameter logic [CMD_W-1:0] FIXED_CMD = 8'h04
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             orbit_start_i,
  input  logic [CMD_W-1:0] user_cmd_i,
  input  logic             send_req_i,
  output logic             cmd_valid_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic             req_clr_o
);
  localparam int unsigned BX_W = $clog2(ORBIT_LEN);
  localparam int unsigned PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [BX_W-1:0] bx;
  logic            orbit_begin;
  logic            presc_fire;
  logic            fixed_hit;
  logic            user_hit;

  bsched_bx_ctr #(
    .ORBIT_LEN(ORBIT_LEN),
    .BX_W     (BX_W)
  ) u_bx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .orbit_start_i(orbit_start_i),
    .bx_o         (bx),
    .orbit_begin_o(orbit_begin)
  );

  bsched_orbit_presc #(
    .PRESCALE(PRESCALE),
    .PS_W    (PS_W)
  ) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(orbit_begin),
    .fire_o(presc_fire)
  );

  assign fixed_hit = presc_fire && (bx == BX_W'(FIXED_POS));
  assign user_hit  = (bx == BX_W'(USER_POS));

  bsched_issue #(
    .FIXED_CMD(FIXED_CMD)
  ) u_issue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fixed_hit_i(fixed_hit),
    .user_hit_i (user_hit),
    .user_req_i (send_req_i),
    .user_cmd_i (user_cmd_i),
    .cmd_valid_o(cmd_valid_o),
    .cmd_o      (cmd_o),
    .req_clr_o  (req_clr_o)
  );

  p_user_slot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_clr_o) |-> ($past(bx) == BX_W'(USER_POS)));
  p_fixed_slot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_valid_o && !req_clr_o) |-> ($past(bx) == BX_W'(FIXED_POS)));
endmodule

// File: tb/bcast_sched_test.sv
`timescale 1ns/1ps
module bcast_sched_test;
  localparam int OL = 3564;
  localparam int FP = 3400;
  localparam int UP = 1024;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       orbit_start = 1'b0;
  logic [7:0] user_cmd = 8'h00;
  logic       send_req = 1'b0;
  logic       cmd_valid;
  logic [7:0] cmd;
  logic       req_clr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int e0, e2;

  int       log_cyc [0:15];
  int       log_cmd [0:15];
  int       log_clr [0:15];
  int       n_log = 0;

  always #5 clk = ~clk;

  bcast_sched uut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .orbit_start_i(orbit_start),
    .user_cmd_i   (user_cmd),
    .send_req_i   (send_req),
    .cmd_valid_o  (cmd_valid),
    .cmd_o        (cmd),
    .req_clr_o    (req_clr)
  );

  always @(posedge clk) cyc = cyc + 1;

  // strobe logger plus register-block emulation of the auto-clear
  always @(negedge clk) begin
    if (cmd_valid && n_log < 16) begin
      log_cyc[n_log] = cyc;
      log_cmd[n_log] = int'(cmd);
      log_clr[n_log] = int'(req_clr);
      n_log = n_log + 1;
    end
    if (req_clr) send_req = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
               req, what, act, act, exp, exp);
    end
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic marker(output int e);
    @(negedge clk);
    orbit_start = 1'b1;
    e = cyc + 1;
    @(negedge clk);
    orbit_start = 1'b0;
  endtask

  task automatic expect_entry(input int i, input int t, input int c, input int clr,
                              input string req);
    chk(log_cyc[i] == t, req, "strobe edge", log_cyc[i], t);
    chk(log_cmd[i] == c, req, "command byte", log_cmd[i], c);
    chk(log_clr[i] == clr, req, "auto-clear flag", log_clr[i], clr);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(cmd_valid == 1'b0, "R1", "valid in reset", int'(cmd_valid), 0);
    chk(cmd == 8'h00, "R1", "cmd in reset", int'(cmd), 0);
    chk(req_clr == 1'b0, "R1", "clr in reset", int'(req_clr), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(cmd_valid == 1'b0 && req_clr == 1'b0, "R1", "outputs after release",
        int'({cmd_valid, req_clr}), 0);
  endtask

  task automatic t_fixed_first;
    user_cmd = 8'hA5;
    send_req = 1'b0;
    marker(e0);
    n_log = 0;
    wait_to(e0 + OL);
    chk(n_log == 1, "R9", "strobes in orbit 0", n_log, 1);
    if (n_log >= 1) expect_entry(0, e0 + FP + 1, 8'h04, 0, "R3");
    chk(cmd == 8'h00, "R9", "idle cmd", int'(cmd), 0);
  endtask

  task automatic t_user_early;
    n_log = 0;
    wait_to(e0 + OL + 200);
    user_cmd = 8'h5A;
    send_req = 1'b1;
    wait_to(e0 + 2 * OL);
    chk(n_log == 1, "R6", "strobes in orbit 1", n_log, 1);
    if (n_log >= 1) expect_entry(0, e0 + OL + UP + 1, 8'h5A, 1, "R8");
  endtask

  task automatic t_user_late;
    n_log = 0;
    wait_to(e0 + 2 * OL + 2000);
    user_cmd = 8'h3C;
    send_req = 1'b1;
    wait_to(e0 + 3 * OL);
    chk(n_log == 0, "R7", "no send in request orbit", n_log, 0);
    wait_to(e0 + 4 * OL);
    chk(n_log == 1, "R7", "deferred strobes", n_log, 1);
    if (n_log >= 1) expect_entry(0, e0 + 3 * OL + UP + 1, 8'h3C, 1, "R7");
  endtask

  task automatic t_quiet;
    n_log = 0;
    user_cmd = 8'hFF;
    send_req = 1'b0;
    wait_to(e0 + 10 * OL);
    chk(n_log == 0, "R10", "strobes in orbits 4..9", n_log, 0);
    chk(n_log == 0, "R4", "prescaled-out orbits silent", n_log, 0);
  endtask

  task automatic t_both;
    n_log = 0;
    wait_to(e0 + 10 * OL + 100);
    user_cmd = 8'h81;
    send_req = 1'b1;
    wait_to(e0 + 11 * OL);
    chk(n_log == 2, "R5", "strobes in orbit 10", n_log, 2);
    if (n_log >= 2) begin
      expect_entry(0, e0 + 10 * OL + UP + 1, 8'h81, 1, "R6");
      expect_entry(1, e0 + 10 * OL + FP + 1, 8'h04, 0, "R4");
    end
  endtask

  task automatic t_realign;
    wait_to(e0 + 11 * OL + 500);
    marker(e2);
    n_log = 0;
    wait_to(e2 + 8 * OL);
    chk(n_log == 0, "R4", "no fixed before 8 orbits", n_log, 0);
    wait_to(e2 + 9 * OL);
    chk(n_log == 1, "R2", "strobes after realign", n_log, 1);
    if (n_log >= 1) expect_entry(0, e2 + 8 * OL + FP + 1, 8'h04, 0, "R4");
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1500000;
    chk(1'b0, "WDOG", "watchdog expired", cyc, 0);
    finish_up();
  end

  initial begin
    t_reset();
    t_fixed_first();
    t_user_early();
    t_user_late();
    t_quiet();
    t_both();
    t_realign();
    finish_up();
  end
endmodule